// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker steps a transfer engine through a linked list of buffer descriptors kept in shared memory, for one direction of one channel. Each descriptor takes three 32-bit words at consecutive word addresses. The first word (offset 0) is the pointer to the next descriptor. The second word (offset 4) is the buffer address. The third word (offset 8) carries the byte count in bits 15:0 and a stop flag in bit 31. The walker reads a descriptor one word at a time, hands the buffer address and length to the transfer engine, waits for that engine to finish, and raises an interrupt pulse. It then decides whether to follow the next pointer.

A mode input picks how the list ends. In flag mode the walker stops on a descriptor whose stop flag is set, and a host poll command makes it read that descriptor again. In tail mode the walker stops once the current descriptor address equals a host-written tail address, and a fresh tail write makes it read the descriptor again and compare once more. The host appends descriptors and moves the end marker while the walker only reads memory.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, `mem_req`, `xfer_start` and `irq` are low and no memory read is issued until `head_wr` is pulsed. The walk then starts at `head_addr`. A poll command before the walk starts has no effect.
- R2: A descriptor at address A is read with three requests to A, A+4 and A+8, in that order, one at a time. `mem_addr` holds steady while `mem_req` is high and no `mem_ack` has arrived.
- R3: After all three words are read, `xfer_start` pulses for exactly one cycle with `xfer_buf` = word 1 and `xfer_len` = word 2 bits 15:0. No memory read is issued from that pulse until `xfer_done`.
- R4: Each `xfer_done` during a transfer is followed in the next cycle by a one-cycle `irq` pulse, with `irq_desc` equal to the address of that descriptor.
- R5: In flag mode (`mode_tail` = 0), when a descriptor has word 2 bit 31 = 0, the walker fetches the descriptor at word 0 after its transfer.
- R6: In flag mode, a descriptor with bit 31 = 1 halts the walker after its transfer. A poll then re-reads all three words. If the flag is now 0, the walker goes on to the new next pointer without repeating the transfer. Otherwise it halts again.
- R7: A poll command is ignored while a transfer is in progress, while the walker is idle, and at any time in tail mode.
- R8: In tail mode (`mode_tail` = 1), the walker follows the next pointer while the current descriptor address differs from the tail address, whatever the value of word 2 bit 31.
- R9: In tail mode, once the current address equals the tail, the walker halts. A later tail write re-reads the descriptor. It advances if the current address now differs from the tail, and halts again otherwise.
- R10: In flag mode, a poll command that arrives during a descriptor fetch is kept pending. If that descriptor then halts the walker, the pending poll triggers the re-read without a further command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tail | input | 1 | 0: stop flag ends the list; 1: tail address ends the list (static while walking) |
| head_wr | input | 1 | Start pulse, taken only while idle |
| head_addr | input | AW | First descriptor address |
| tail_wr | input | 1 | Tail address write strobe |
| tail_addr | input | AW | New tail address |
| poll_cmd | input | 1 | Host poll command pulse |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DW | Read data |
| xfer_start | output | 1 | One-cycle start to the transfer engine |
| xfer_buf | output | AW | Buffer address for the transfer |
| xfer_len | output | LENW | Byte count for the transfer |
| xfer_done | input | 1 | Transfer engine completion pulse |
| irq | output | 1 | One-cycle completion interrupt |
| irq_desc | output | AW | Address of the completed descriptor |

## Verification
The hardest case to reach is a host command that lands inside a narrow window: a poll during a fetch that has to survive until the halt, or a poll during a transfer that must leave no trace. The stimulus waits at the ports for the first `mem_req` or the `xfer_start` pulse and issues the command in that same cycle. It then counts every memory read so that any extra re-read shows up. Recovery from a halt is reached by rewriting descriptors in the bench memory while the walker is stopped, then issuing the poll or tail write. Randomly sized chains with random acknowledge and completion latencies cover the plain walking path.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_HALT
  } walk_state_e;

  localparam int DCW_AW   = 32;
  localparam int DCW_DW   = 32;
  localparam int DCW_LENW = 16;
  localparam int DCW_FLAG = 31;
  localparam int DCW_NWORDS = 3;
endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch #(
  parameter int AW     = dcw_pkg::DCW_AW,
  parameter int DW     = dcw_pkg::DCW_DW,
  parameter int LENW   = dcw_pkg::DCW_LENW,
  parameter int FLAG   = dcw_pkg::DCW_FLAG,
  parameter int NWORDS = dcw_pkg::DCW_NWORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] nxt_ptr,
  output logic [AW-1:0] buf_addr,
  output logic [LENW-1:0] buf_len,
  output logic          stop_flag
);
  localparam int STEP = DW / 8;
  localparam int IW   = $clog2(NWORDS);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

  logic [IW-1:0] idx;
  logic [DW-1:0] word_q [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      idx      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !mem_req) begin
        mem_req  <= 1'b1;
        mem_addr <= base;
        idx      <= '0;
      end else if (mem_req && mem_ack) begin
        if (idx == LAST) begin
          mem_req <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_addr <= mem_addr + AW'(STEP);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_req && mem_ack) word_q[idx] <= mem_rdata;
  end

  assign nxt_ptr   = word_q[0][AW-1:0];
  assign buf_addr  = word_q[1][AW-1:0];
  assign buf_len   = word_q[2][LENW-1:0];
  assign stop_flag = word_q[2][FLAG];
endmodule

// File: rtl/dcw_host_regs.sv
module dcw_host_regs #(
  parameter int AW = dcw_pkg::DCW_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_addr,
  input  logic          poll_cmd,
  input  logic          poll_arm,
  input  logic          tail_arm,
  input  logic          clear,
  output logic [AW-1:0] tail_q,
  output logic          poll_pend,
  output logic          tail_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q    <= '0;
      poll_pend <= 1'b0;
      tail_pend <= 1'b0;
    end else begin
      if (tail_wr) tail_q <= tail_addr;
      poll_pend <= (poll_pend && !clear) || (poll_cmd && poll_arm);
      tail_pend <= (tail_pend && !clear) || (tail_wr && tail_arm);
    end
  end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker #(
  parameter int AW   = dcw_pkg::DCW_AW,
  parameter int DW   = dcw_pkg::DCW_DW,
  parameter int LENW = dcw_pkg::DCW_LENW,
  parameter int FLAG = dcw_pkg::DCW_FLAG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_tail,
  input  logic            head_wr,
  input  logic [AW-1:0]   head_addr,
  input  logic            tail_wr,
  input  logic [AW-1:0]   tail_addr,
  input  logic            poll_cmd,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            xfer_start,
  output logic [AW-1:0]   xfer_buf,
  output logic [LENW-1:0] xfer_len,
  input  logic            xfer_done,
  output logic            irq,
  output logic [AW-1:0]   irq_desc
);
  import dcw_pkg::*;

  walk_state_e   state;
  logic [AW-1:0] cur;
  logic          recheck;

  logic          f_go, f_done, f_flag;
  logic [AW-1:0] f_base, f_nxt, f_buf;
  logic [LENW-1:0] f_len;
  logic [AW-1:0] tail_q;
  logic          poll_pend, tail_pend;
  logic          stop, decide, trig, clear;

  dcw_fetch #(.AW(AW), .DW(DW), .LENW(LENW), .FLAG(FLAG)) u_fetch (
    .clk(clk), .rst(rst), .go(f_go), .base(f_base),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .done(f_done),
    .nxt_ptr(f_nxt), .buf_addr(f_buf), .buf_len(f_len), .stop_flag(f_flag)
  );

  dcw_host_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .tail_wr(tail_wr), .tail_addr(tail_addr),
    .poll_cmd(poll_cmd),
    .poll_arm(!mode_tail && (state == ST_FETCH || state == ST_HALT)),
    .tail_arm(mode_tail && state != ST_IDLE),
    .clear(clear), .tail_q(tail_q), .poll_pend(poll_pend), .tail_pend(tail_pend)
  );

  // end-of-list test for the descriptor just read
  assign stop   = mode_tail ? (cur == tail_q) : f_flag;
  assign decide = (state == ST_FETCH && f_done && recheck) ||
                  (state == ST_XFER && xfer_done);
  assign trig   = (state == ST_HALT) && (mode_tail ? tail_pend : poll_pend);
  assign clear  = (decide && !stop) || trig;

  always_comb begin
    f_go   = 1'b0;
    f_base = cur;
    unique case (state)
      ST_IDLE:  begin f_go = head_wr; f_base = head_addr; end
      ST_FETCH,
      ST_XFER:  begin f_go = decide && !stop; f_base = f_nxt; end
      ST_HALT:  begin f_go = trig; f_base = cur; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur        <= '0;
      recheck    <= 1'b0;
      xfer_start <= 1'b0;
      xfer_buf   <= '0;
      xfer_len   <= '0;
      irq        <= 1'b0;
      irq_desc   <= '0;
    end else begin
      xfer_start <= 1'b0;
      irq        <= 1'b0;
      unique case (state)
        ST_IDLE: if (head_wr) begin
          cur     <= head_addr;
          recheck <= 1'b0;
          state   <= ST_FETCH;
        end
        ST_FETCH: if (f_done) begin
          if (!recheck) begin
            xfer_start <= 1'b1;
            xfer_buf   <= f_buf;
            xfer_len   <= f_len;
            state      <= ST_XFER;
          end else if (!stop) begin
            cur     <= f_nxt;
            recheck <= 1'b0;
          end else begin
            state <= ST_HALT;
          end
        end
        ST_XFER: if (xfer_done) begin
          irq      <= 1'b1;
          irq_desc <= cur;
          if (!stop) begin
            cur   <= f_nxt;
            state <= ST_FETCH;
          end else begin
            state <= ST_HALT;
          end
        end
        ST_HALT: if (trig) begin
          recheck <= 1'b1;
          state   <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          xfer_start,
  input logic          xfer_done,
  input logic          irq
);
  logic in_xfer;

  always_ff @(posedge clk) begin
    if (rst) in_xfer <= 1'b0;
    else if (xfer_start) in_xfer <= 1'b1;
    else if (xfer_done) in_xfer <= 1'b0;
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  p_no_read_in_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    in_xfer |-> !mem_req);

  p_irq_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(xfer_done));
endmodule

bind desc_chain_walker dcw_checker #(.AW(AW)) u_dcw_checker (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .xfer_start(xfer_start), .xfer_done(xfer_done), .irq(irq)
);

// File: tb/desc_chain_walker_test.sv
`timescale 1ns/1ps
module desc_chain_walker_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, mode_tail, head_wr, tail_wr, poll_cmd;
  logic [AW-1:0] head_addr, tail_addr;
  logic mem_req, mem_ack, xfer_start, xfer_done, irq;
  logic [AW-1:0] mem_addr, xfer_buf, irq_desc;
  logic [31:0] mem_rdata;
  logic [15:0] xfer_len;

  desc_chain_walker uut (
    .clk(clk), .rst(rst), .mode_tail(mode_tail), .head_wr(head_wr), .head_addr(head_addr),
    .tail_wr(tail_wr), .tail_addr(tail_addr), .poll_cmd(poll_cmd),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_buf(xfer_buf), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .irq(irq), .irq_desc(irq_desc)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:511];
  logic [31:0] exp_rd [0:511];
  logic [31:0] xs_buf [0:63];
  logic [15:0] xs_len [0:63];
  logic [31:0] irq_log [0:63];
  int rd_n, exp_n, xs_n, irq_n;
  int mem_wait, xcd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: random acknowledge latency, logs every completed read
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; mem_wait = -1;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_wait = -1;
      end else if (mem_req && !rst) begin
        if (mem_wait < 0) mem_wait = $urandom_range(0, 2);
        if (mem_wait == 0) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[9:2]];
          if (rd_n < 512) begin rd_log[rd_n] = mem_addr; rd_n++; end
        end else mem_wait--;
      end
    end
  end

  // transfer engine model and interrupt monitor
  initial begin
    xfer_done = 1'b0; xcd = -1;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (irq && irq_n < 64) begin irq_log[irq_n] = irq_desc; irq_n++; end
      if (xfer_start) begin
        if (xs_n < 64) begin xs_buf[xs_n] = xfer_buf; xs_len[xs_n] = xfer_len; xs_n++; end
        xcd = $urandom_range(1, 3);
      end else if (xcd > 0) begin
        xcd--;
        if (xcd == 0) begin xfer_done = 1'b1; xcd = -1; end
      end
    end
  end

  function automatic logic [31:0] ctl_word(input logic [15:0] len, input bit flag);
    return {flag, 15'b0, len};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] b,
                          input logic [15:0] len, input bit flag);
    mem[a[9:2]]     = nxt;
    mem[a[9:2] + 1] = b;
    mem[a[9:2] + 2] = ctl_word(len, flag);
  endtask

  task automatic do_reset(input bit tmode);
    rst = 1'b1; mode_tail = tmode; head_wr = 0; tail_wr = 0; poll_cmd = 0;
    head_addr = '0; tail_addr = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rd_n = 0; exp_n = 0; xs_n = 0; irq_n = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_head(input logic [31:0] a);
    head_addr = a; head_wr = 1'b1; @(negedge clk); head_wr = 1'b0;
  endtask
  task automatic pulse_tail(input logic [31:0] a);
    tail_addr = a; tail_wr = 1'b1; @(negedge clk); tail_wr = 1'b0;
  endtask
  task automatic pulse_poll();
    poll_cmd = 1'b1; @(negedge clk); poll_cmd = 1'b0;
  endtask
  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic exp_desc(input logic [31:0] a);
    exp_rd[exp_n] = a; exp_rd[exp_n+1] = a + 4; exp_rd[exp_n+2] = a + 8;
    exp_n += 3;
  endtask

  task automatic cmp_reads(input string tag);
    chk(rd_n == exp_n, {tag, " read count"}, rd_n, exp_n);
    for (int i = 0; i < exp_n && i < rd_n; i++)
      chk(rd_log[i] == exp_rd[i], {tag, " read address"}, rd_log[i], exp_rd[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rb [0:7];
    logic [15:0] rl [0:7];
    void'($urandom(32'd20240611));

    // R1: reset state, no activity before head, poll while idle ignored
    do_reset(1'b0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    chk(xfer_start == 1'b0, "R1 xfer_start after reset", xfer_start, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    pulse_poll();
    repeat (20) @(negedge clk);
    chk(rd_n == 0, "R1 R7 no read before head", rd_n, 0);

    // R2 R3 R4 R5 R7: flag-mode chain, poll during first transfer ignored
    put_desc(32'h100, 32'h200, 32'hA000, 16'h0010, 1'b0);
    put_desc(32'h200, 32'h300, 32'hB000, 16'h0020, 1'b0);
    put_desc(32'h300, 32'h000, 32'hC000, 16'h0030, 1'b1);
    pulse_head(32'h100);
    while (!xfer_start) @(negedge clk);
    pulse_poll();
    settle();
    exp_desc(32'h100); exp_desc(32'h200); exp_desc(32'h300);
    cmp_reads("R2 R5 R7 flag chain");
    chk(xs_n == 3, "R3 transfer count", xs_n, 3);
    chk(xs_buf[0] == 32'hA000, "R3 buffer 0", xs_buf[0], 32'hA000);
    chk(xs_len[1] == 16'h0020, "R3 length 1", {16'h0, xs_len[1]}, 32'h20);
    chk(xs_buf[2] == 32'hC000, "R3 buffer 2", xs_buf[2], 32'hC000);
    chk(irq_n == 3, "R4 irq count", irq_n, 3);
    chk(irq_log[0] == 32'h100, "R4 irq desc 0", irq_log[0], 32'h100);
    chk(irq_log[2] == 32'h300, "R4 irq desc 2", irq_log[2], 32'h300);

    // R6: poll with flag still set re-reads and halts again
    pulse_poll();
    settle();
    exp_desc(32'h300);
    cmp_reads("R6 poll flag still set");
    chk(xs_n == 3, "R6 no repeated transfer", xs_n, 3);

    // R6: flag cleared and list extended, poll advances
    put_desc(32'h300, 32'h400, 32'hC000, 16'h0030, 1'b0);
    put_desc(32'h400, 32'h000, 32'hD000, 16'h0044, 1'b1);
    pulse_poll();
    settle();
    exp_desc(32'h300); exp_desc(32'h400);
    cmp_reads("R6 poll advance");
    chk(xs_n == 4, "R6 transfer count", xs_n, 4);
    chk(xs_buf[3] == 32'hD000, "R6 new buffer", xs_buf[3], 32'hD000);
    chk(irq_log[3] == 32'h400, "R6 irq desc", irq_log[3], 32'h400);

    // R10: poll during the first fetch is held until the halt
    do_reset(1'b0);
    put_desc(32'h100, 32'h200, 32'h0001, 16'h0005, 1'b1);
    pulse_head(32'h100);
    while (!mem_req) @(negedge clk);
    pulse_poll();
    settle();
    exp_desc(32'h100); exp_desc(32'h100);
    cmp_reads("R10 pending poll");
    chk(xs_n == 1, "R10 single transfer", xs_n, 1);

    // R8 R9 R7: tail mode; stop flags set everywhere must not matter
    do_reset(1'b1);
    put_desc(32'h100, 32'h200, 32'h1100, 16'h0001, 1'b1);
    put_desc(32'h200, 32'h300, 32'h2200, 16'h0002, 1'b1);
    put_desc(32'h300, 32'h000, 32'h3300, 16'h0003, 1'b1);
    pulse_tail(32'h300);
    pulse_head(32'h100);
    settle();
    exp_desc(32'h100); exp_desc(32'h200); exp_desc(32'h300);
    cmp_reads("R8 tail chain");
    chk(xs_n == 3, "R8 transfer count", xs_n, 3);
    pulse_poll();
    settle();
    chk(rd_n == 9, "R7 poll ignored in tail mode", rd_n, 9);
    pulse_tail(32'h300);
    settle();
    exp_desc(32'h300);
    cmp_reads("R9 tail unchanged");
    chk(xs_n == 3, "R9 no transfer on equal tail", xs_n, 3);
    put_desc(32'h300, 32'h400, 32'h3300, 16'h0003, 1'b1);
    put_desc(32'h400, 32'h000, 32'h4400, 16'h0004, 1'b1);
    pulse_tail(32'h400);
    settle();
    exp_desc(32'h300); exp_desc(32'h400);
    cmp_reads("R9 tail moved");
    chk(xs_n == 4, "R9 transfer count", xs_n, 4);
    chk(irq_log[3] == 32'h400, "R9 irq desc", irq_log[3], 32'h400);

    // R5 R3 R4: random flag-mode chains
    for (int it = 0; it < 4; it++) begin
      int n;
      do_reset(1'b0);
      n = $urandom_range(2, 6);
      for (int i = 0; i < n; i++) begin
        logic [31:0] a;
        a = 32'h40 * (i + 1);
        rb[i] = $urandom;
        rl[i] = 16'($urandom_range(1, 65535));
        put_desc(a, a + 32'h40, rb[i], rl[i], i == n - 1);
        exp_desc(a);
      end
      pulse_head(32'h40);
      settle();
      cmp_reads("R5 random chain");
      chk(xs_n == n, "R3 random transfer count", xs_n, n);
      chk(irq_n == n, "R4 random irq count", irq_n, n);
      for (int i = 0; i < n && i < xs_n; i++) begin
        chk(xs_buf[i] == rb[i], "R3 random buffer", xs_buf[i], rb[i]);
        chk(xs_len[i] == rl[i], "R3 random length", {16'h0, xs_len[i]}, {16'h0, rl[i]});
        chk(irq_log[i] == 32'h40 * (i + 1), "R4 random irq desc", irq_log[i], 32'h40 * (i + 1));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule